// File: doc/BRIEF.md
# Register Window State Controller

This block holds the window bookkeeping for a CPU core whose integer registers are arranged in overlapping windows. The state is a current window pointer and four counters: how many windows can still be saved, how many can be restored, how many belong to another context, and how many are clean. The pipeline sends one of four window commands (save, restore, saved, restored) together with a six-bit window-state value. The block then does one of three things. It commits the command and updates its state, or it raises a trap that names a handler vector and a handler type, or, for an illegal saved/restored, it flags an error and leaves the state alone.

Commands enter on a valid/ready channel. A command transfers on a rising edge where both `cmd_valid` and `cmd_ready` are high, and the sender must hold the op code and window-state value steady until that edge. `cmd_ready` is low during reset. It is also low for exactly one cycle after any trap, which gives the trap logic one bubble to take over before the next command is accepted. Every result is registered. The updated state, the trap pulse and the error pulse all appear in the cycle after the accepting edge. The window count and the reset values of three counters are parameters.

Top module: `rwin_ctrl`

## Requirements
- R1: During reset, `cmd_ready`, `trap_valid` and `cmd_err` are low. After reset, the pointer is 0, can-save is N_WIN-2, and can-restore, other-window and clean-window hold the values of RST_CANRESTORE, RST_OTHERWIN and RST_CLEANWIN.
- R2: A save accepted with can-save equal to 0 raises a trap. If other-window is nonzero it is a spill-other trap (kind 2) typed by window-state bits [5:3]. Otherwise it is a spill-normal trap (kind 1) typed by bits [2:0].
- R3: A save accepted with can-save nonzero and clean-window equal to can-restore raises a clean-window trap (kind 5, type 0). The spill check of R2 has priority over this one.
- R4: A save that traps neither way advances the pointer by one, wrapping from N_WIN-1 to 0. It also decrements can-save and increments can-restore.
- R5: A restore accepted with can-restore equal to 0 raises a fill trap. If other-window is nonzero it is fill-other (kind 4) typed by bits [5:3]. Otherwise it is fill-normal (kind 3) typed by bits [2:0].
- R6: A restore that does not trap moves the pointer back by one, wrapping from 0 to N_WIN-1. It also increments can-save and decrements can-restore.
- R7: A trapped save or restore changes neither the pointer nor any counter.
- R8: A legal saved increments can-save. It then decrements can-restore if other-window is 0, and decrements other-window otherwise. The sum of can-save, can-restore and other-window never changes.
- R9: A legal restored increments can-restore. It then decrements can-save if other-window is 0, and decrements other-window otherwise.
- R10: A saved is illegal when can-save equals N_WIN-2, or when other-window and can-restore are both 0. A restored is illegal when can-restore equals N_WIN-2, or when other-window and can-save are both 0. An illegal command gives a one-cycle `cmd_err` pulse and leaves all state unchanged.
- R11: `trap_valid` is a one-cycle pulse in the cycle after the accepting edge. In that same cycle `cmd_ready` is low, so a command held by the sender is taken one cycle later. Trap kind codes are 0 none, 1 spill-normal, 2 spill-other, 3 fill-normal, 4 fill-other, 5 clean-window. Op codes are 0 save, 1 restore, 2 saved, 3 restored.
- R12: In a cycle that follows no accepted command, the state does not change and neither `trap_valid` nor `cmd_err` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 2 | Command code (0 save, 1 restore, 2 saved, 3 restored) |
| cmd_wstate | input | 6 | Window-state value; [2:0] normal type, [5:3] other type |
| cwp | output | $clog2(N_WIN) | Current window pointer |
| cansave | output | CNT_W | Windows that can be saved |
| canrestore | output | CNT_W | Windows that can be restored |
| otherwin | output | CNT_W | Windows owned by another context |
| cleanwin | output | CNT_W | Clean windows |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_kind | output | 3 | Trap vector code |
| trap_type | output | 3 | Handler type from the window-state value |
| cmd_err | output | 1 | One-cycle pulse for an illegal saved/restored |

## Verification
Within one command, the two trap conditions of a save can both be true at once: can-save is zero while clean-window also equals can-restore. The block must also combine a trap with the ready bubble that holds back the command after it. The bench reaches the clean-window state and both spill states through real command sequences, and it issues commands back to back so that the next command is already waiting during each trap pulse. A scoreboard judges both effects. It compares trap kind, trap type and the unchanged state in the pulse cycle, requires `cmd_ready` to be low in that cycle, and then confirms that the waiting command was taken exactly once, one cycle later.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  typedef enum logic [1:0] {
    OP_SAVE     = 2'd0,
    OP_RESTORE  = 2'd1,
    OP_SAVED    = 2'd2,
    OP_RESTORED = 2'd3
  } rwin_op_e;

  typedef enum logic [2:0] {
    TK_NONE    = 3'd0,
    TK_SPILL_N = 3'd1,
    TK_SPILL_O = 3'd2,
    TK_FILL_N  = 3'd3,
    TK_FILL_O  = 3'd4,
    TK_CLEAN   = 3'd5
  } rwin_trap_e;
endpackage

// File: rtl/rwin_ptr_step.sv
module rwin_ptr_step #(
  parameter int N_WIN = 8,
  parameter int PTR_W = $clog2(N_WIN)
) (
  input  logic [PTR_W-1:0] cur,
  output logic [PTR_W-1:0] up,
  output logic [PTR_W-1:0] down
);
  localparam bit               IS_POW2 = ((N_WIN & (N_WIN - 1)) == 0);
  localparam logic [PTR_W-1:0] ONE     = PTR_W'(1);
  localparam logic [PTR_W-1:0] TOP     = PTR_W'(N_WIN - 1);

  generate
    if (IS_POW2) begin : g_pow2
      assign up   = cur + ONE;
      assign down = cur - ONE;
    end else begin : g_any
      assign up   = (cur == TOP) ? '0 : cur + ONE;
      assign down = (cur == '0) ? TOP : cur - ONE;
    end
  endgenerate
endmodule

// File: rtl/rwin_next.sv
module rwin_next
  import rwin_pkg::*;
#(
  parameter int N_WIN = 8,
  parameter int PTR_W = $clog2(N_WIN),
  parameter int CNT_W = $clog2(N_WIN) + 1
) (
  input  rwin_op_e         op,
  input  logic [5:0]       wstate,
  input  logic [PTR_W-1:0] cwp,
  input  logic [CNT_W-1:0] cs,
  input  logic [CNT_W-1:0] cr,
  input  logic [CNT_W-1:0] ow,
  input  logic [CNT_W-1:0] cl,
  output logic             wr,
  output logic [PTR_W-1:0] n_cwp,
  output logic [CNT_W-1:0] n_cs,
  output logic [CNT_W-1:0] n_cr,
  output logic [CNT_W-1:0] n_ow,
  output rwin_trap_e       tk,
  output logic [2:0]       tt,
  output logic             ill
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(N_WIN - 2);

  logic [PTR_W-1:0] ptr_up, ptr_dn;
  logic [CNT_W-1:0] clean_gap;
  logic             ow_zero;

  rwin_ptr_step #(.N_WIN(N_WIN), .PTR_W(PTR_W)) u_step (
    .cur (cwp),
    .up  (ptr_up),
    .down(ptr_dn)
  );

  assign clean_gap = cl - cr;
  assign ow_zero   = (ow == '0);

  always_comb begin
    wr    = 1'b0;
    ill   = 1'b0;
    tk    = TK_NONE;
    tt    = 3'd0;
    n_cwp = cwp;
    n_cs  = cs;
    n_cr  = cr;
    n_ow  = ow;
    unique case (op)
      OP_SAVE: begin
        if (cs == '0) begin
          tk = ow_zero ? TK_SPILL_N : TK_SPILL_O;
          tt = ow_zero ? wstate[2:0] : wstate[5:3];
        end else if (clean_gap == '0) begin
          tk = TK_CLEAN;
        end else begin
          wr    = 1'b1;
          n_cwp = ptr_up;
          n_cs  = cs - ONE;
          n_cr  = cr + ONE;
        end
      end
      OP_RESTORE: begin
        if (cr == '0) begin
          tk = ow_zero ? TK_FILL_N : TK_FILL_O;
          tt = ow_zero ? wstate[2:0] : wstate[5:3];
        end else begin
          wr    = 1'b1;
          n_cwp = ptr_dn;
          n_cs  = cs + ONE;
          n_cr  = cr - ONE;
        end
      end
      OP_SAVED: begin
        if (cs == LIM || (ow_zero && cr == '0)) begin
          ill = 1'b1;
        end else begin
          wr   = 1'b1;
          n_cs = cs + ONE;
          if (ow_zero) n_cr = cr - ONE;
          else         n_ow = ow - ONE;
        end
      end
      OP_RESTORED: begin
        if (cr == LIM || (ow_zero && cs == '0)) begin
          ill = 1'b1;
        end else begin
          wr   = 1'b1;
          n_cr = cr + ONE;
          if (ow_zero) n_cs = cs - ONE;
          else         n_ow = ow - ONE;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rwin_state.sv
module rwin_state #(
  parameter int N_WIN          = 8,
  parameter int PTR_W          = $clog2(N_WIN),
  parameter int CNT_W          = $clog2(N_WIN) + 1,
  parameter int RST_CANRESTORE = 0,
  parameter int RST_OTHERWIN   = 0,
  parameter int RST_CLEANWIN   = N_WIN - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] n_cwp,
  input  logic [CNT_W-1:0] n_cs,
  input  logic [CNT_W-1:0] n_cr,
  input  logic [CNT_W-1:0] n_ow,
  output logic [PTR_W-1:0] cwp,
  output logic [CNT_W-1:0] cs,
  output logic [CNT_W-1:0] cr,
  output logic [CNT_W-1:0] ow,
  output logic [CNT_W-1:0] cl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp <= '0;
      cs  <= CNT_W'(N_WIN - 2);
      cr  <= CNT_W'(RST_CANRESTORE);
      ow  <= CNT_W'(RST_OTHERWIN);
      cl  <= CNT_W'(RST_CLEANWIN);
    end else if (load) begin
      cwp <= n_cwp;
      cs  <= n_cs;
      cr  <= n_cr;
      ow  <= n_ow;
    end
  end
endmodule

// File: rtl/rwin_evt.sv
module rwin_evt
  import rwin_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  rwin_trap_e tk,
  input  logic [2:0] tt,
  input  logic       ill,
  output logic       trap_valid,
  output logic [2:0] trap_kind,
  output logic [2:0] trap_type,
  output logic       err,
  output logic       ready
);
  logic hit;
  assign hit = acc && (tk != TK_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_valid <= 1'b0;
      trap_kind  <= 3'd0;
      trap_type  <= 3'd0;
      err        <= 1'b0;
      ready      <= 1'b0;
    end else begin
      trap_valid <= hit;
      trap_kind  <= hit ? tk : TK_NONE;
      trap_type  <= hit ? tt : 3'd0;
      err        <= acc && ill;
      ready      <= !hit;
    end
  end
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
  import rwin_pkg::*;
#(
  parameter int N_WIN          = 8,
  parameter int CNT_W          = $clog2(N_WIN) + 1,
  parameter int RST_CANRESTORE = 0,
  parameter int RST_OTHERWIN   = 0,
  parameter int RST_CLEANWIN   = N_WIN - 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [1:0]               cmd_op,
  input  logic [5:0]               cmd_wstate,
  output logic [$clog2(N_WIN)-1:0] cwp,
  output logic [CNT_W-1:0]         cansave,
  output logic [CNT_W-1:0]         canrestore,
  output logic [CNT_W-1:0]         otherwin,
  output logic [CNT_W-1:0]         cleanwin,
  output logic                     trap_valid,
  output logic [2:0]               trap_kind,
  output logic [2:0]               trap_type,
  output logic                     cmd_err
);
  localparam int PTR_W = $clog2(N_WIN);

  logic             acc, wr, ill;
  logic [PTR_W-1:0] n_cwp;
  logic [CNT_W-1:0] n_cs, n_cr, n_ow;
  rwin_trap_e       tk;
  logic [2:0]       tt;

  assign acc = cmd_valid && cmd_ready;

  rwin_next #(.N_WIN(N_WIN), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_next (
    .op    (rwin_op_e'(cmd_op)),
    .wstate(cmd_wstate),
    .cwp   (cwp),
    .cs    (cansave),
    .cr    (canrestore),
    .ow    (otherwin),
    .cl    (cleanwin),
    .wr    (wr),
    .n_cwp (n_cwp),
    .n_cs  (n_cs),
    .n_cr  (n_cr),
    .n_ow  (n_ow),
    .tk    (tk),
    .tt    (tt),
    .ill   (ill)
  );

  rwin_state #(
    .N_WIN(N_WIN), .PTR_W(PTR_W), .CNT_W(CNT_W),
    .RST_CANRESTORE(RST_CANRESTORE), .RST_OTHERWIN(RST_OTHERWIN),
    .RST_CLEANWIN(RST_CLEANWIN)
  ) u_state (
    .clk  (clk),
    .rst_n(rst_n),
    .load (acc && wr),
    .n_cwp(n_cwp),
    .n_cs (n_cs),
    .n_cr (n_cr),
    .n_ow (n_ow),
    .cwp  (cwp),
    .cs   (cansave),
    .cr   (canrestore),
    .ow   (otherwin),
    .cl   (cleanwin)
  );

  rwin_evt u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .tk        (tk),
    .tt        (tt),
    .ill       (ill),
    .trap_valid(trap_valid),
    .trap_kind (trap_kind),
    .trap_type (trap_type),
    .err       (cmd_err),
    .ready     (cmd_ready)
  );
endmodule

// File: rtl/rwin_ctrl_chk.sv
module rwin_ctrl_chk #(
  parameter int PTR_W = 3,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [PTR_W-1:0] cwp,
  input logic [CNT_W-1:0] cansave,
  input logic [CNT_W-1:0] canrestore,
  input logic [CNT_W-1:0] otherwin,
  input logic             trap_valid,
  input logic             cmd_err
);
  logic [CNT_W+1:0] pool;
  assign pool = (CNT_W+2)'(cansave) + (CNT_W+2)'(canrestore) + (CNT_W+2)'(otherwin);

  // R11
  trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> !trap_valid);

  // R11
  trap_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> !cmd_ready);

  // R7
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> ($stable(cwp) && $stable(cansave) && $stable(canrestore) && $stable(otherwin)));

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> ($stable(cwp) && $stable(cansave) && $stable(canrestore)
                 && $stable(otherwin) && !trap_valid));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_valid && cmd_ready) |-> ($stable(cwp) && $stable(cansave) && !trap_valid && !cmd_err));

  // R8
  pool_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pool));
endmodule

bind rwin_ctrl rwin_ctrl_chk #(.PTR_W($clog2(N_WIN)), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cwp       (cwp),
  .cansave   (cansave),
  .canrestore(canrestore),
  .otherwin  (otherwin),
  .trap_valid(trap_valid),
  .cmd_err   (cmd_err)
);

// File: tb/sim_rwin_ctrl.sv
`timescale 1ns/1ps
module sim_rwin_ctrl;
  localparam int NW = 8;
  localparam int CW = 4;
  localparam int PW = 3;
  localparam int RCR = 0;
  localparam int ROW = 2;
  localparam int RCL = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'd0;
  logic [5:0]    cmd_wstate = 6'd0;
  logic [PW-1:0] cwp;
  logic [CW-1:0] cansave, canrestore, otherwin, cleanwin;
  logic          trap_valid, cmd_err;
  logic [2:0]    trap_kind, trap_type;

  always #2 clk = ~clk;

  rwin_ctrl #(.N_WIN(NW), .CNT_W(CW), .RST_CANRESTORE(RCR),
              .RST_OTHERWIN(ROW), .RST_CLEANWIN(RCL)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wstate(cmd_wstate), .cwp(cwp), .cansave(cansave),
    .canrestore(canrestore), .otherwin(otherwin), .cleanwin(cleanwin),
    .trap_valid(trap_valid), .trap_kind(trap_kind), .trap_type(trap_type),
    .cmd_err(cmd_err)
  );

  typedef struct {
    logic          tv;
    logic [2:0]    tk;
    logic [2:0]    tt;
    logic          er;
    logic [PW-1:0] cwp;
    logic [CW-1:0] cs, cr, ow;
    string         tag;
  } exp_t;

  exp_t q[$];
  int n_run = 0, n_fail = 0;
  bit run = 1'b0, done = 1'b0, acc_q = 1'b0;

  // reference model state (advanced when a command is handed over)
  logic [PW-1:0] m_cwp = '0;
  logic [CW-1:0] m_cs = CW'(NW-2), m_cr = CW'(RCR), m_ow = CW'(ROW);
  // state last confirmed by the scoreboard
  logic [PW-1:0] l_cwp = '0;
  logic [CW-1:0] l_cs = CW'(NW-2), l_cr = CW'(RCR), l_ow = CW'(ROW);

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [5:0] ws, input string tag);
    exp_t e;
    cmd_op = op; cmd_wstate = ws; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    e.tv = 0; e.tk = 0; e.tt = 0; e.er = 0; e.tag = tag;
    case (op)
      2'd0: if (m_cs == 0) begin
              e.tv = 1; e.tk = (m_ow != 0) ? 3'd2 : 3'd1;
              e.tt = (m_ow != 0) ? ws[5:3] : ws[2:0];
            end else if (m_cr == CW'(RCL)) begin
              e.tv = 1; e.tk = 3'd5;
            end else begin
              m_cwp = PW'((int'(m_cwp) + 1) % NW); m_cs--; m_cr++;
            end
      2'd1: if (m_cr == 0) begin
              e.tv = 1; e.tk = (m_ow != 0) ? 3'd4 : 3'd3;
              e.tt = (m_ow != 0) ? ws[5:3] : ws[2:0];
            end else begin
              m_cwp = PW'((int'(m_cwp) + NW - 1) % NW); m_cs++; m_cr--;
            end
      2'd2: if (m_cs == CW'(NW-2) || (m_ow == 0 && m_cr == 0)) e.er = 1;
            else begin m_cs++; if (m_ow == 0) m_cr--; else m_ow--; end
      default: if (m_cr == CW'(NW-2) || (m_ow == 0 && m_cs == 0)) e.er = 1;
            else begin m_cr++; if (m_ow == 0) m_cs--; else m_ow--; end
    endcase
    e.cwp = m_cwp; e.cs = m_cs; e.cr = m_cr; e.ow = m_ow;
    q.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  always @(posedge clk) acc_q <= cmd_valid && cmd_ready;

  // scoreboard monitor
  always @(negedge clk) begin
    if (run) begin
      if (acc_q) begin
        exp_t e;
        if (q.size() == 0) begin
          chk(0, "R12", "unexpected accept", 1, 0);
        end else begin
          bit ok;
          e = q.pop_front();
          ok = (trap_valid == e.tv) && (trap_kind == e.tk) && (trap_type == e.tt)
               && (cmd_err == e.er) && (cwp == e.cwp) && (cansave == e.cs)
               && (canrestore == e.cr) && (otherwin == e.ow);
          chk(ok, e.tag, "tv/kind/type/err/cwp/cs/cr/ow",
              {trap_valid, trap_kind, trap_type, cmd_err, cwp, cansave, canrestore, otherwin},
              {e.tv, e.tk, e.tt, e.er, e.cwp, e.cs, e.cr, e.ow});
          if (e.tv) chk(cmd_ready == 1'b0, "R11", "ready in trap cycle", cmd_ready, 0);
          l_cwp = e.cwp; l_cs = e.cs; l_cr = e.cr; l_ow = e.ow;
        end
      end else begin
        chk(!trap_valid && !cmd_err && cwp == l_cwp && cansave == l_cs
            && canrestore == l_cr && otherwin == l_ow, "R12", "idle hold",
            {trap_valid, cmd_err, cwp, cansave, canrestore, otherwin},
            {2'b00, l_cwp, l_cs, l_cr, l_ow});
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset outputs
    chk(!cmd_ready && !trap_valid && !cmd_err, "R1", "ready/trap/err in reset",
        {cmd_ready, trap_valid, cmd_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cwp == 0 && cansave == CW'(NW-2) && canrestore == CW'(RCR) && otherwin == CW'(ROW)
        && cleanwin == CW'(RCL) && cmd_ready, "R1", "post-reset state",
        {cwp, cansave, canrestore, otherwin, cleanwin, cmd_ready},
        {PW'(0), CW'(NW-2), CW'(RCR), CW'(ROW), CW'(RCL), 1'b1});
    run = 1'b1;
    issue(2'd2, 6'o00, "R10 saved at limit");
    issue(2'd1, 6'o53, "R5 fill-other");
    for (int i = 0; i < 5; i++) issue(2'd0, 6'o00, "R4 save");
    issue(2'd0, 6'o71, "R3 clean-window");
    issue(2'd3, 6'o00, "R9 restored other");
    issue(2'd3, 6'o00, "R10 restored at limit");
    issue(2'd0, 6'o00, "R4 save");
    issue(2'd0, 6'o62, "R2 spill-other");
    issue(2'd2, 6'o00, "R8 saved other");
    issue(2'd0, 6'o00, "R4 save");
    issue(2'd0, 6'o46, "R2 spill-normal");
    issue(2'd2, 6'o00, "R8 saved normal");
    issue(2'd0, 6'o00, "R4 save wrap");
    issue(2'd1, 6'o00, "R6 restore wrap");
    for (int i = 0; i < 7; i++) issue(2'd1, 6'o00, "R6 restore");
    issue(2'd1, 6'o35, "R5 fill-normal");
    issue(2'd3, 6'o00, "R9 restored normal");
    issue(2'd2, 6'o00, "R8 saved");
    issue(2'd2, 6'o00, "R10 saved none");
    issue(2'd1, 6'o00, "R7 restore");
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R11", "queue drained", q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule